// File: doc/BRIEF.md
# Masked Fast GPIO Port

This block is a 32-pin general-purpose I/O port behind a simple register bus. It holds an output latch, a direction register and a per-pin mask. It also has set and clear strobes for the latch and a pin-value register that software can reach through two views.

The legacy view reads every pin and writes the whole latch, with no regard to the mask. The fast view honours the mask: masked pins read as 0 and keep their latch bits on a write. Because the bus carries per-byte write strobes, the mask can be written as one word, as single byte lanes or as half-word lanes.

Pin inputs pass through a two-flop synchronizer before readback. Each pin has an analog-mode input; while it is high, that pin's digital readback is forced to 0. Reads are combinational on the current address.

Top module: `fgpio_port`

## Requirements
- R1: A read of the pin-value register returns the level each pin had two rising clock edges earlier, whatever the pin's direction bit.
- R2: A pin whose `pin_analog` bit is 1 reads as 0 in both pin-value views.
- R3: A write to the legacy pin-value register (offset 0x00) loads each strobed byte of the output latch from the write data and ignores the mask. A write with all four strobes replaces the whole latch.
- R4: A write to the fast pin-value register (offset 0x14) changes only strobed latch bits whose mask bit is 0. A read of it returns 0 in every masked bit position.
- R5: A read of the legacy pin-value register does not depend on the mask.
- R6: A mask write (offset 0x10) with strobe `bus_be[n]` set updates mask bits 8n to 8n+7 from write data bits 8n to 8n+7, and leaves the other bytes of the mask unchanged.
- R7: A mask write with strobes 0 and 1 updates only mask bits 0 to 15. A mask write with strobes 2 and 3 updates only mask bits 16 to 31. Each half is taken from its own half of the write data.
- R8: After reset the output latch, the direction register, the mask and both synchronizer stages are all 0.
- R9: Writing 1s to the set register (offset 0x04) sets the matching strobed latch bits. Writing 1s to the clear register (offset 0x08) clears them. A 0 in the write data has no effect, and both registers read as 0.
- R10: `pin_out` carries the output latch and `pin_oe` carries the direction register (offset 0x0C, 1 = drive).
- R11: The register offsets are byte addresses decoded on `bus_addr[4:2]`. A read of an unmapped offset (0x18, 0x1C) returns 0, and so does any cycle that is not a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_en | input | 1 | Bus access this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | AW | Byte address of the register |
| bus_be | input | 4 | Per-byte write strobes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational |
| pin_in | input | 32 | Pad input levels |
| pin_analog | input | 32 | Per-pin analog mode select |
| pin_out | output | 32 | Pad output values |
| pin_oe | output | 32 | Pad drive enables |

## Verification
Latch writes are applied with the legacy view, the fast view and the set and clear strobes. Each is tried under an all-zero mask, an all-one mask and mixed masks, which separates the path that honours the mask from the one that ignores it. Mask writes use single-byte strobes, half-word strobe pairs and full words, so that a lane routed to the wrong bits shows up. Pin levels and analog modes change every cycle, so a missing or extra synchronizer stage, or a missing analog gate, gives a wrong readback.

// File: rtl/fgpio_port.sv
module fgpio_port #(
  parameter int AW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_en,
  input  logic          bus_we,
  input  logic [AW-1:0] bus_addr,
  input  logic [3:0]    bus_be,
  input  logic [31:0]   bus_wdata,
  output logic [31:0]   bus_rdata,
  input  logic [31:0]   pin_in,
  input  logic [31:0]   pin_analog,
  output logic [31:0]   pin_out,
  output logic [31:0]   pin_oe
);
  localparam int WW = AW - 2;
  localparam logic [WW-1:0] A_PIN  = WW'(0);
  localparam logic [WW-1:0] A_SET  = WW'(1);
  localparam logic [WW-1:0] A_CLR  = WW'(2);
  localparam logic [WW-1:0] A_DIR  = WW'(3);
  localparam logic [WW-1:0] A_MASK = WW'(4);
  localparam logic [WW-1:0] A_FPIN = WW'(5);

  logic [31:0] out_q, dir_q, mask_q, sync1_q, sync2_q;
  logic [31:0] lane, fast_bits, level;
  logic [WW-1:0] word;
  logic wr, rd;

  assign word  = bus_addr[AW-1:2];
  assign wr    = bus_en & bus_we;
  assign rd    = bus_en & ~bus_we;
  assign lane  = {{8{bus_be[3]}}, {8{bus_be[2]}}, {8{bus_be[1]}}, {8{bus_be[0]}}};
  assign fast_bits = lane & ~mask_q;
  assign level = sync2_q & ~pin_analog;

  assign pin_out = out_q;
  assign pin_oe  = dir_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync1_q <= '0;
      sync2_q <= '0;
    end else begin
      sync1_q <= pin_in;
      sync2_q <= sync1_q;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_q  <= '0;
      dir_q  <= '0;
      mask_q <= '0;
    end else if (wr) begin
      case (word)
        A_PIN:   out_q  <= (out_q & ~lane) | (bus_wdata & lane);
        A_SET:   out_q  <= out_q | (bus_wdata & lane);
        A_CLR:   out_q  <= out_q & ~(bus_wdata & lane);
        A_DIR:   dir_q  <= (dir_q & ~lane) | (bus_wdata & lane);
        A_MASK:  mask_q <= (mask_q & ~lane) | (bus_wdata & lane);
        A_FPIN:  out_q  <= (out_q & ~fast_bits) | (bus_wdata & fast_bits);
        default: ;
      endcase
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (rd) begin
      case (word)
        A_PIN:   bus_rdata = level;
        A_DIR:   bus_rdata = dir_q;
        A_MASK:  bus_rdata = mask_q;
        A_FPIN:  bus_rdata = level & ~mask_q;
        default: bus_rdata = '0;
      endcase
    end
  end

  logic [1:0] age_q;
  always_ff @(posedge clk) begin
    if (!rst_n) age_q <= '0;
    else if (age_q != 2'd2) age_q <= age_q + 2'd1;
  end

  AST_SYNC_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q == 2'd2 && rd && word == A_PIN) |-> bus_rdata == ($past(pin_in, 2) & ~pin_analog)); // R1
  AST_ANALOG_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && (word == A_PIN || word == A_FPIN)) |-> (bus_rdata & pin_analog) == '0); // R2
  AST_LEGACY_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && word == A_PIN && bus_be == 4'hF) |=> pin_out == $past(bus_wdata)); // R3
  AST_FAST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && word == A_FPIN) |=> ((pin_out ^ $past(pin_out)) & $past(mask_q)) == '0); // R4
  AST_FAST_READ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && word == A_FPIN) |-> (bus_rdata & mask_q) == '0); // R4
  AST_SETCLR_READ0: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && (word == A_SET || word == A_CLR)) |-> bus_rdata == '0); // R9
  AST_SET_ONLY_RISES: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && word == A_SET) |=> (($past(pin_out) & ~pin_out) == '0)); // R9
  AST_DIR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr && word == A_DIR) |=> $stable(pin_oe)); // R10
endmodule

// File: tb/sim_fgpio_port.sv
module sim_fgpio_port;
  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_en = 0, bus_we = 0;
  logic [4:0] bus_addr = '0;
  logic [3:0] bus_be = '0;
  logic [31:0] bus_wdata = '0, pin_in = '0, pin_analog = '0;
  logic [31:0] bus_rdata, pin_out, pin_oe;

  always #4 clk = ~clk;

  fgpio_port #(.AW(5)) u0 (.clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_in(pin_in), .pin_analog(pin_analog), .pin_out(pin_out), .pin_oe(pin_oe));

  int vecs = 0, bad = 0;
  string tag = "R8";
  logic [31:0] m_out, m_dir, m_mask;
  logic [31:0] pq[$];

  function automatic logic [31:0] lanes(input logic [3:0] be);
    return {{8{be[3]}}, {8{be[2]}}, {8{be[1]}}, {8{be[0]}}};
  endfunction

  function automatic logic [31:0] exp_rd();
    logic [31:0] lv;
    lv = pq[0] & ~pin_analog;
    if (!(bus_en && !bus_we)) return '0;
    case (bus_addr[4:2])
      3'd0: return lv;
      3'd3: return m_dir;
      3'd4: return m_mask;
      3'd5: return lv & ~m_mask;
      default: return '0;
    endcase
  endfunction

  always @(posedge clk) begin
    logic [31:0] bm, wm, drop;
    if (!rst_n) begin
      m_out = '0; m_dir = '0; m_mask = '0;
      pq = {32'h0, 32'h0};
    end else begin
      bm = lanes(bus_be);
      if (bus_en && bus_we) begin
        case (bus_addr[4:2])
          3'd0: m_out = (m_out & ~bm) | (bus_wdata & bm);
          3'd1: m_out = m_out | (bus_wdata & bm);
          3'd2: m_out = m_out & ~(bus_wdata & bm);
          3'd3: m_dir = (m_dir & ~bm) | (bus_wdata & bm);
          3'd4: m_mask = (m_mask & ~bm) | (bus_wdata & bm);
          3'd5: begin wm = bm & ~m_mask; m_out = (m_out & ~wm) | (bus_wdata & wm); end
          default: ;
        endcase
      end
      pq.push_back(pin_in);
      drop = pq.pop_front();
    end
  end

  task automatic cmp(input logic [31:0] act, input logic [31:0] exp, input string what);
    vecs++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: got %h expected %h at %0t", tag, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    cmp(bus_rdata, exp_rd(), "bus_rdata");
    cmp(pin_out, m_out, "pin_out (R10)");
    cmp(pin_oe, m_dir, "pin_oe (R10)");
  end

  task automatic op(input logic en, input logic we, input logic [4:0] a,
                    input logic [3:0] be, input logic [31:0] d);
    @(posedge clk); #1;
    bus_en = en; bus_we = we; bus_addr = a; bus_be = be; bus_wdata = d;
  endtask

  task automatic rdall();
    for (int a = 0; a < 8; a++) op(1, 0, 5'(a * 4), 4'h0, '0);
  endtask

  initial begin
    fork
      begin #1600000; bad++; $display("FAIL watchdog: got hang expected finish"); end
      begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        tag = "R8"; rdall();
        tag = "R10"; op(1, 1, 5'h0C, 4'hF, 32'hF0F0_1234);
        tag = "R3"; op(1, 1, 5'h00, 4'hF, 32'hDEAD_BEEF); op(1, 1, 5'h00, 4'h2, 32'h0000_5500);
        tag = "R9"; op(1, 1, 5'h04, 4'hF, 32'h0000_00F0); op(1, 1, 5'h08, 4'hF, 32'h0F00_000F);
        op(1, 0, 5'h04, 0, 0); op(1, 0, 5'h08, 0, 0);
        tag = "R6"; op(1, 1, 5'h10, 4'h4, 32'hA5C3_7E11); rdall();
        tag = "R7"; op(1, 1, 5'h10, 4'h3, 32'hFFFF_00FF); op(1, 1, 5'h10, 4'hC, 32'h1234_FFFF); rdall();
        tag = "R4"; op(1, 1, 5'h14, 4'hF, 32'h5555_AAAA); op(1, 0, 5'h14, 0, 0);
        tag = "R5"; pin_in = 32'hFFFF_FFFF; op(1, 1, 5'h10, 4'hF, 32'hFFFF_FFFF);
        op(1, 0, 5'h00, 0, 0); op(1, 0, 5'h00, 0, 0); op(1, 0, 5'h14, 0, 0);
        tag = "R3"; op(1, 1, 5'h00, 4'hF, 32'h0BAD_F00D);
        tag = "R2"; pin_analog = 32'h00FF_00F0; op(1, 0, 5'h00, 0, 0); op(1, 0, 5'h14, 0, 0);
        pin_analog = '0;
        tag = "R1";
        for (int i = 0; i < 20; i++) begin
          op(1, 0, 5'h00, 0, 0); pin_in = $urandom;
        end
        tag = "R11"; op(1, 0, 5'h18, 0, 0); op(1, 0, 5'h1C, 0, 0); op(0, 0, 5'h0C, 0, 0);
        tag = "R1 R2 R3 R4 R6 R7 R9";
        for (int i = 0; i < 4000; i++) begin
          int k;
          k = $urandom_range(0, 9);
          pin_in = $urandom;
          pin_analog = ($urandom_range(0, 3) == 0) ? $urandom : 32'h0;
          op($urandom_range(0, 7) != 0, k < 5, 5'(($urandom_range(0, 7)) * 4),
             4'($urandom), (k == 1) ? 32'hFFFF_FFFF : $urandom);
        end
        tag = "R8"; @(posedge clk); #1 rst_n = 1'b0; bus_en = 0;
        @(posedge clk); #1 rst_n = 1'b1; rdall();
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end
endmodule